// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a read or write burst in a double-data-rate memory controller's data path. A command strobe supplies a start column, a burst length (two, four, eight beats, or a whole 512-column page) and an ordering (linear wrap or XOR interleave). From the cycle after the strobe, the block presents one column per data-pair cycle. It flags the final beat and then goes idle.

A running burst can be cut short in two ways. A stop input ends it. A restart input replaces it with a new burst that begins on the next cycle. Whole-page bursts wrap at the top of the row and run until they are stopped. A page burst with an odd start column, or one that asks for interleave ordering, is refused: the block raises an error pulse and does not start the burst. Data capture, latency delay and strobe generation happen elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `err_o` are low. `col_o` reads zero whenever `valid_o` is low.
- R2: Linear ordering (`order_i`=0) with `blen_i` 0, 1 or 2 gives a burst of 2, 4 or 8 beats. On beat i, the low 1, 2 or 3 column bits equal (start low bits + i) modulo the length, so the count wraps inside its aligned block.
- R3: Interleave ordering (`order_i`=1) with `blen_i` 0, 1 or 2 gives beat i the low bits of the start column XOR i.
- R4: Column bits above the burst-length field keep the start column's value for the whole burst.
- R5: A strobe sampled on a rising edge makes beat 0 visible after that edge. The burst then advances one beat per cycle. `last_o` is high exactly on the final beat, and `valid_o` drops on the next cycle unless a restart is taken.
- R6: `blen_i`=3 selects a whole-page linear burst. It starts at an even column, counts up modulo 512, never raises `last_o`, and runs until stopped or restarted.
- R7: `stop_i` sampled while a burst is running makes the next cycle idle. No further column is issued.
- R8: A page burst request that is odd-aligned or uses interleave raises `err_o` for one cycle after the strobe and starts no burst. A refused restart leaves the running burst untouched.
- R9: `restart_i` sampled while a burst runs cuts the burst, and the next cycle shows beat 0 of the new burst. Restart takes priority over `stop_i` in the same cycle.
- R10: `start_i` while a burst runs, and `restart_i` while idle, are ignored. Neither changes the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per data-pair cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst when idle |
| restart_i | input | 1 | Replace the running burst with a new one |
| stop_i | input | 1 | End the running burst |
| start_col_i | input | COL_W | Start column for start or restart |
| blen_i | input | 2 | Length code: 0=2, 1=4, 2=8, 3=page |
| order_i | input | 1 | 0 linear, 1 interleave |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is being issued |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Previous strobe was refused |

## Verification
The bench builds the block with its default column width of 9 bits. At that width a page burst really wraps from 511 to 0, and the top start columns (0x1FC and above) show that the upper bits hold while the low field wraps. Directed bursts cover every length and ordering, restart and stop at mid-burst and on the same cycle, and ignored strobes. Seeded random bursts then cover the wider space of start columns.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int unsigned COL_W_DEF = 9;

    typedef enum logic [1:0] {
        BL_TWO   = 2'd0,
        BL_FOUR  = 2'd1,
        BL_EIGHT = 2'd2,
        BL_PAGE  = 2'd3
    } blen_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        blen_e  len;
        order_e ord;
    } burst_cfg_t;

    // number of wrapping low bits for a finite burst; 0 means page
    function automatic int unsigned field_bits(input blen_e len);
        case (len)
            BL_TWO:   return 1;
            BL_FOUR:  return 2;
            BL_EIGHT: return 3;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/burst_cmd_check.sv
module burst_cmd_check #(
    parameter int unsigned COL_W = 9
) (
    input  logic [COL_W-1:0]         start_col,
    input  burst_seq_pkg::burst_cfg_t cfg,
    output logic                     legal
);
    import burst_seq_pkg::*;

    always_comb begin
        legal = 1'b1;
        if (cfg.len == BL_PAGE) begin
            if (cfg.ord == ORD_XOR) legal = 1'b0;
            if (start_col[0])       legal = 1'b0;
        end
    end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
    parameter int unsigned COL_W = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic                      stop,
    input  logic [COL_W-1:0]          col_in,
    input  burst_seq_pkg::burst_cfg_t cfg_in,
    input  logic [COL_W-1:0]          span_mask,
    output logic                      active,
    output logic [COL_W-1:0]          beat,
    output logic [COL_W-1:0]          base,
    output burst_seq_pkg::burst_cfg_t cfg_q,
    output logic                      final_beat
);
    import burst_seq_pkg::*;

    assign final_beat = active && (cfg_q.len != BL_PAGE) && (beat == span_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            beat   <= '0;
            base   <= '0;
            cfg_q  <= '{len: BL_TWO, ord: ORD_LINEAR};
        end else if (load) begin
            active <= 1'b1;
            beat   <= '0;
            base   <= col_in;
            cfg_q  <= cfg_in;
        end else if (active) begin
            if (stop || final_beat) begin
                active <= 1'b0;
                beat   <= '0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int unsigned COL_W = 9
) (
    input  logic [COL_W-1:0]          base,
    input  logic [COL_W-1:0]          beat,
    input  burst_seq_pkg::burst_cfg_t cfg,
    output logic [COL_W-1:0]          span_mask,
    output logic [COL_W-1:0]          col
);
    import burst_seq_pkg::*;

    logic [COL_W-1:0] lin_sum;
    logic [COL_W-1:0] xor_mix;
    logic [COL_W-1:0] low_sel;

    always_comb begin
        int unsigned nb;
        nb = field_bits(cfg.len);
        if (nb == 0) span_mask = '1;
        else         span_mask = COL_W'((1 << nb) - 1);
    end

    assign lin_sum = base + beat;
    assign xor_mix = base ^ beat;
    assign low_sel = (cfg.ord == ORD_XOR) ? xor_mix : lin_sum;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col[b] = span_mask[b] ? low_sel[b] : base[b];
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
    parameter int unsigned COL_W = burst_seq_pkg::COL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             restart_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       blen_i,
    input  logic             order_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    import burst_seq_pkg::*;

    burst_cfg_t       cfg_req;
    burst_cfg_t       cfg_cur;
    logic             legal;
    logic             accept;
    logic             load;
    logic             active;
    logic             final_beat;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] span_mask;
    logic [COL_W-1:0] col_raw;

    assign cfg_req = '{len: blen_e'(blen_i), ord: order_e'(order_i)};
    assign accept  = active ? restart_i : start_i;
    assign load    = accept && legal;

    burst_cmd_check #(.COL_W(COL_W)) u_check (
        .start_col (start_col_i),
        .cfg       (cfg_req),
        .legal     (legal)
    );

    burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .stop       (stop_i),
        .col_in     (start_col_i),
        .cfg_in     (cfg_req),
        .span_mask  (span_mask),
        .active     (active),
        .beat       (beat),
        .base       (base),
        .cfg_q      (cfg_cur),
        .final_beat (final_beat)
    );

    burst_col_gen #(.COL_W(COL_W)) u_gen (
        .base      (base),
        .beat      (beat),
        .cfg       (cfg_cur),
        .span_mask (span_mask),
        .col       (col_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) err_o <= 1'b0;
        else     err_o <= accept && !legal;
    end

    assign valid_o = active;
    assign last_o  = final_beat;
    assign col_o   = active ? col_raw : '0;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int unsigned COL_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             restart_i,
    input logic             stop_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [1:0]       blen_i,
    input logic             order_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             err_o
);
    logic bad_req;
    assign bad_req = (blen_i == 2'd3) && (order_i || start_col_i[0]);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!valid_o && !err_o && !last_o));

    assert_idle_col_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (col_o == '0));

    assert_last_in_burst_R5: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    assert_end_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_o && last_o && !restart_i) |=> !valid_o);

    assert_low_bit_toggles_R2: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !stop_i && !restart_i)
        |=> (valid_o && (col_o[0] != $past(col_o[0]))));

    assert_stop_idles_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && stop_i && !restart_i) |=> !valid_o);

    assert_reject_R8: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && start_i && bad_req) |=> (!valid_o && err_o));

    assert_restart_beat0_R9: assert property (@(posedge clk) disable iff (rst)
        (valid_o && restart_i && !bad_req)
        |=> (valid_o && col_o == $past(start_col_i)));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .restart_i   (restart_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .blen_i      (blen_i),
    .order_i     (order_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst;
    logic             start_i, restart_i, stop_i;
    logic [COL_W-1:0] start_col_i;
    logic [1:0]       blen_i;
    logic             order_i;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, err_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .restart_i(restart_i),
        .stop_i(stop_i), .start_col_i(start_col_i), .blen_i(blen_i),
        .order_i(order_i), .col_o(col_o), .valid_o(valid_o),
        .last_o(last_o), .err_o(err_o)
    );

    function automatic int blen_beats(input logic [1:0] b);
        return (b == 2'd3) ? 512 : (2 << b);
    endfunction

    // expected column of beat i, written from R2, R3, R4, R6
    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
            input logic [1:0] b, input logic o, input int i);
        int len, lo, hi, l;
        len = blen_beats(b);
        lo  = int'(s) % len;
        hi  = int'(s) - lo;
        l   = o ? (lo ^ (i % len)) : ((lo + i) % len);
        return COL_W'(hi + l);
    endfunction

    task automatic check(input string req, input logic ev, input logic [COL_W-1:0] ec,
                         input logic el, input logic ee);
        total++;
        if (valid_o !== ev || col_o !== ec || last_o !== el || err_o !== ee) begin
            bad++;
            $display("FAIL %s: got valid=%0b col=%0h last=%0b err=%0b exp valid=%0b col=%0h last=%0b err=%0b",
                     req, valid_o, col_o, last_o, err_o, ev, ec, el, ee);
        end
    endtask

    task automatic idle_inputs();
        start_i = 0; restart_i = 0; stop_i = 0;
    endtask

    // called at a negedge: present a strobe, return at the next negedge
    task automatic strobe(input logic s, input logic r, input logic p,
            input logic [COL_W-1:0] c, input logic [1:0] b, input logic o);
        start_i = s; restart_i = r; stop_i = p;
        start_col_i = c; blen_i = b; order_i = o;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic full_burst(input string req, input logic [COL_W-1:0] s,
            input logic [1:0] b, input logic o);
        int len;
        len = blen_beats(b);
        strobe(1, 0, 0, s, b, o);
        for (int i = 0; i < len; i++) begin
            check(req, 1'b1, exp_col(s, b, o, i), i == len - 1, 1'b0);
            @(negedge clk);
        end
        check({req, " end R5"}, 1'b0, '0, 1'b0, 1'b0);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        idle_inputs();
        start_col_i = '0; blen_i = '0; order_i = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 reset", 1'b0, '0, 1'b0, 1'b0);

        full_burst("R2 lin s5 bl8", 9'd5, 2'd2, 1'b0);
        full_burst("R3 xor s5 bl8", 9'd5, 2'd2, 1'b1);
        full_burst("R2 lin s3 bl4", 9'd3, 2'd1, 1'b0);
        full_burst("R3 xor s2 bl4", 9'd2, 2'd1, 1'b1);
        full_burst("R2 lin s1 bl2", 9'd1, 2'd0, 1'b0);
        full_burst("R4 hi bits 1FD bl4", 9'h1FD, 2'd1, 1'b0);
        full_burst("R4 hi bits 0AB bl8 xor", 9'h0AB, 2'd2, 1'b1);

        // R6 page burst wraps past 511, then R7 stop
        strobe(1, 0, 0, 9'd508, 2'd3, 1'b0);
        for (int i = 0; i < 7; i++) begin
            check("R6 page wrap", 1'b1, exp_col(9'd508, 2'd3, 1'b0, i), 1'b0, 1'b0);
            if (i < 6) @(negedge clk);
        end
        strobe(0, 0, 1, '0, 2'd0, 1'b0);
        check("R7 stop page", 1'b0, '0, 1'b0, 1'b0);

        // R7 stop in a finite burst
        strobe(1, 0, 0, 9'h040, 2'd2, 1'b1);
        check("R7 beat0", 1'b1, 9'h040, 1'b0, 1'b0);
        strobe(0, 0, 1, '0, 2'd0, 1'b0);
        check("R7 stop bl8", 1'b0, '0, 1'b0, 1'b0);

        // R8 refused page requests
        strobe(1, 0, 0, 9'h011, 2'd3, 1'b0);
        check("R8 odd page", 1'b0, '0, 1'b0, 1'b1);
        @(negedge clk);
        check("R8 err one cycle", 1'b0, '0, 1'b0, 1'b0);
        strobe(1, 0, 0, 9'h010, 2'd3, 1'b1);
        check("R8 xor page", 1'b0, '0, 1'b0, 1'b1);
        @(negedge clk);

        // R9 restart mid burst
        strobe(1, 0, 0, 9'h000, 2'd2, 1'b0);
        check("R9 old b0", 1'b1, 9'h000, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 old b1", 1'b1, 9'h001, 1'b0, 1'b0);
        strobe(0, 1, 1, 9'h022, 2'd1, 1'b1);
        for (int i = 0; i < 4; i++) begin
            check("R9 new burst", 1'b1, exp_col(9'h022, 2'd1, 1'b1, i), i == 3, 1'b0);
            @(negedge clk);
        end
        check("R9 new end", 1'b0, '0, 1'b0, 1'b0);

        // R8 refused restart keeps the running burst
        strobe(1, 0, 0, 9'h080, 2'd1, 1'b0);
        strobe(0, 1, 0, 9'h003, 2'd3, 1'b0);
        check("R8 refused restart", 1'b1, 9'h081, 1'b0, 1'b1);
        @(negedge clk); @(negedge clk); @(negedge clk);

        // R10 start while busy and restart while idle are ignored
        strobe(1, 0, 0, 9'h008, 2'd1, 1'b0);
        strobe(1, 0, 0, 9'h100, 2'd2, 1'b1);
        check("R10 start busy", 1'b1, 9'h009, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 start busy", 1'b1, 9'h00A, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 start busy", 1'b1, 9'h00B, 1'b1, 1'b0);
        @(negedge clk);
        strobe(0, 1, 0, 9'h055, 2'd1, 1'b0);
        check("R10 restart idle", 1'b0, '0, 1'b0, 1'b0);

        // seeded random bursts (R2 R3 R4 R6)
        for (int k = 0; k < 40; k++) begin
            logic [COL_W-1:0] s;
            logic [1:0] b;
            logic o;
            s = COL_W'($urandom);
            b = 2'($urandom);
            o = 1'($urandom);
            if (b == 2'd3) begin
                s[0] = 1'b0;
                strobe(1, 0, 0, s, b, 1'b0);
                for (int i = 0; i < 10; i++) begin
                    check("R6 rand page", 1'b1, exp_col(s, b, 1'b0, i), 1'b0, 1'b0);
                    if (i < 9) @(negedge clk);
                end
                strobe(0, 0, 1, '0, 2'd0, 1'b0);
                check("R7 rand stop", 1'b0, '0, 1'b0, 1'b0);
            end else begin
                full_burst(o ? "R3 rand" : "R2 rand", s, b, o);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run exp finished run");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule